// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a processor core that retires one RV32I integer instruction on every rising clock edge. The program counter drives a read-only instruction port. The returned instruction word is decoded in the same cycle. Two registers are read and an operand pair is formed. The ALU produces either a result or an address. A taken branch or a jump reloads the program counter, and the result is written back at the next edge. There is no pipeline and no stall. Both memory ports are expected to answer combinationally within the cycle.

The core handles register-register and register-immediate arithmetic, loads of any width, word stores, the six conditional branches, both jumps, and the two upper-immediate instructions. Branch and jump targets are formed by the main ALU, using the program counter as the first operand and the immediate as the second. A separate comparator decides whether a branch is taken. Opcodes the core does not handle retire as no-ops: nothing is written, and the program counter steps by four.

Top module: `rv32_onecycle_core`

## Requirements
- R1: Unless a taken branch or a jump redirects it, the program counter (seen on `imem_addr`) advances by 4 at every rising edge.
- R2: Register 0 reads as zero at all times, and any write aimed at it is discarded.
- R3: Register-register operations use opcode 0110011 and are selected by funct3 = inst[14:12]: 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical right shift, 110 or, 111 and. With inst[30]=1, 000 becomes subtract and 101 becomes arithmetic right shift.
- R4: Register-immediate operations use opcode 0010011 with the same funct3 map and a sign-extended inst[31:20]. Shifts take their amount from imm[4:0]. inst[30] selects an arithmetic right shift only when funct3 is 101, and never turns an add into a subtract.
- R5: Opcode 0110111 writes inst[31:12] followed by twelve zero bits to rd. Opcode 0010111 writes the program counter plus that value to rd.
- R6: Branches (opcode 1100011) compare rs1 with rs2. The funct3 codes are 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. A taken branch moves the PC by the sign-extended B immediate, an even offset. A branch that is not taken steps by 4. No branch writes a register.
- R7: Opcode 1101111 writes PC+4 to rd and jumps by the J immediate. Opcode 1100111 writes PC+4 to rd and jumps to rs1 plus the I immediate, with bit 0 of the target forced to zero.
- R8: Loads (opcode 0000011) read from rs1 plus the sign-extended 12-bit offset. The lane is picked by address bits [1:0]. The funct3 codes are 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword.
- R9: Stores (opcode 0100011) assert `dmem_we` for exactly their own cycle. They present rs1 plus the S immediate (inst[31:25] then inst[11:7]) as the address and the full rs2 word as data. They never write a register, and no other instruction drives `dmem_we`.
- R10: A synchronous reset sets the program counter to `RESET_PC` (default 0) and clears every register. `dmem_we` stays low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of a load or store |
| dmem_wdata | output | 32 | Store data (rs2) |
| dmem_rdata | input | 32 | Word containing `dmem_addr`, combinational |
| dmem_we | output | 1 | Write strobe, high during a store cycle |

## Verification
Every instruction's effects appear at the single rising edge that ends its cycle. A register result is therefore readable by the very next instruction, and a store's word is in memory one edge after its fetch. The bench drives and samples only on falling edges, so the program counter it reads is always the one for the instruction now being executed. Results are not compared cycle by cycle. Each computed value is stored to a dedicated data-memory word by an instruction placed right after it, and those words are compared only once the program counter has reached the final self-loop. Every one of these writes has then had its edge, whatever path the program took. Program-counter-relative results are predicted from the addresses the bench itself assigned when it laid the program out.

// File: rtl/rv32_onecycle_core.sv
module rv32_onecycle_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_we
);
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam logic [1:0] WB_MEM = 2'd0;
  localparam logic [1:0] WB_ALU = 2'd1;
  localparam logic [1:0] WB_PC4 = 2'd2;

  localparam logic [3:0] ALU_ADD  = 4'd0;
  localparam logic [3:0] ALU_SUB  = 4'd1;
  localparam logic [3:0] ALU_SLL  = 4'd2;
  localparam logic [3:0] ALU_SLT  = 4'd3;
  localparam logic [3:0] ALU_SLTU = 4'd4;
  localparam logic [3:0] ALU_XOR  = 4'd5;
  localparam logic [3:0] ALU_SRL  = 4'd6;
  localparam logic [3:0] ALU_SRA  = 4'd7;
  localparam logic [3:0] ALU_OR   = 4'd8;
  localparam logic [3:0] ALU_AND  = 4'd9;
  localparam logic [3:0] ALU_PASS = 4'd10;

  logic [31:0] pc, pc_plus4, pc_next;
  logic [31:0] regs [NREG];
  logic [31:0] imm, op_a, op_b, alu_y, rs1_v, rs2_v, load_v, wb_v, lane;
  logic [6:0]  opcode;
  logic [2:0]  f3;
  logic [RIDX-1:0] rd, rs1, rs2;
  logic        alt;
  logic        a_pc, b_imm, rf_we, mem_we, is_br, is_jal, is_jalr;
  logic [1:0]  wb_sel;
  logic [3:0]  alu_op;
  logic        br_eq, br_lt, br_taken, redirect;

  assign opcode = imem_data[6:0];
  assign rd     = imem_data[11:7];
  assign f3     = imem_data[14:12];
  assign rs1    = imem_data[19:15];
  assign rs2    = imem_data[24:20];
  assign alt    = imem_data[30];

  function automatic logic [3:0] pick_op(input logic [2:0] fn, input logic a);
    case (fn)
      3'b000:  pick_op = a ? ALU_SUB : ALU_ADD;
      3'b001:  pick_op = ALU_SLL;
      3'b010:  pick_op = ALU_SLT;
      3'b011:  pick_op = ALU_SLTU;
      3'b100:  pick_op = ALU_XOR;
      3'b101:  pick_op = a ? ALU_SRA : ALU_SRL;
      3'b110:  pick_op = ALU_OR;
      default: pick_op = ALU_AND;
    endcase
  endfunction

  always_comb begin
    a_pc    = 1'b0;
    b_imm   = 1'b0;
    rf_we   = 1'b0;
    mem_we  = 1'b0;
    is_br   = 1'b0;
    is_jal  = 1'b0;
    is_jalr = 1'b0;
    wb_sel  = WB_ALU;
    alu_op  = ALU_ADD;
    case (opcode)
      OPC_REG:   begin rf_we = 1'b1; alu_op = pick_op(f3, alt); end
      OPC_IMM:   begin rf_we = 1'b1; b_imm = 1'b1;
                       alu_op = pick_op(f3, alt && (f3 == 3'b101)); end
      OPC_LOAD:  begin rf_we = 1'b1; b_imm = 1'b1; wb_sel = WB_MEM; end
      OPC_STORE: begin mem_we = 1'b1; b_imm = 1'b1; end
      OPC_BR:    begin is_br = 1'b1; a_pc = 1'b1; b_imm = 1'b1; end
      OPC_JAL:   begin is_jal = 1'b1; rf_we = 1'b1; a_pc = 1'b1; b_imm = 1'b1; wb_sel = WB_PC4; end
      OPC_JALR:  begin is_jalr = 1'b1; rf_we = 1'b1; b_imm = 1'b1; wb_sel = WB_PC4; end
      OPC_LUI:   begin rf_we = 1'b1; b_imm = 1'b1; alu_op = ALU_PASS; end
      OPC_AUIPC: begin rf_we = 1'b1; a_pc = 1'b1; b_imm = 1'b1; end
      default:   ;
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_STORE: imm = {{21{imem_data[31]}}, imem_data[30:25], imem_data[11:7]};
      OPC_BR:    imm = {{20{imem_data[31]}}, imem_data[7], imem_data[30:25], imem_data[11:8], 1'b0};
      OPC_JAL:   imm = {{12{imem_data[31]}}, imem_data[19:12], imem_data[20], imem_data[30:21], 1'b0};
      OPC_LUI, OPC_AUIPC: imm = {imem_data[31:12], 12'h000};
      default:   imm = {{21{imem_data[31]}}, imem_data[30:20]};
    endcase
  end

  assign rs1_v = regs[rs1];
  assign rs2_v = regs[rs2];
  assign op_a  = a_pc ? pc : rs1_v;
  assign op_b  = b_imm ? imm : rs2_v;

  always_comb begin
    case (alu_op)
      ALU_ADD:  alu_y = op_a + op_b;
      ALU_SUB:  alu_y = op_a - op_b;
      ALU_SLL:  alu_y = op_a << op_b[4:0];
      ALU_SLT:  alu_y = {31'd0, $signed(op_a) < $signed(op_b)};
      ALU_SLTU: alu_y = {31'd0, op_a < op_b};
      ALU_XOR:  alu_y = op_a ^ op_b;
      ALU_SRL:  alu_y = op_a >> op_b[4:0];
      ALU_SRA:  alu_y = $unsigned($signed(op_a) >>> op_b[4:0]);
      ALU_OR:   alu_y = op_a | op_b;
      ALU_AND:  alu_y = op_a & op_b;
      default:  alu_y = op_b;
    endcase
  end

  assign br_eq = (rs1_v == rs2_v);
  assign br_lt = f3[1] ? (rs1_v < rs2_v) : ($signed(rs1_v) < $signed(rs2_v));

  always_comb begin
    case (f3)
      3'b000:  br_taken = br_eq;
      3'b001:  br_taken = !br_eq;
      3'b100, 3'b110: br_taken = br_lt;
      3'b101, 3'b111: br_taken = !br_lt;
      default: br_taken = 1'b0;
    endcase
  end

  assign redirect = is_jal || is_jalr || (is_br && br_taken);
  assign pc_plus4 = pc + 32'd4;

  always_comb begin
    if (is_jalr)                          pc_next = {alu_y[31:1], 1'b0};
    else if (is_jal || (is_br && br_taken)) pc_next = alu_y;
    else                                  pc_next = pc_plus4;
  end

  assign lane = dmem_rdata >> {alu_y[1:0], 3'b000};

  always_comb begin
    case (f3)
      3'b000:  load_v = {{24{lane[7]}}, lane[7:0]};
      3'b001:  load_v = {{16{lane[15]}}, lane[15:0]};
      3'b100:  load_v = {24'd0, lane[7:0]};
      3'b101:  load_v = {16'd0, lane[15:0]};
      default: load_v = dmem_rdata;
    endcase
  end

  always_comb begin
    case (wb_sel)
      WB_MEM:  wb_v = load_v;
      WB_PC4:  wb_v = pc_plus4;
      default: wb_v = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (rf_we && rd != '0) begin
      regs[rd] <= wb_v;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_v;
  assign dmem_we    = mem_we && !rst;

  assert_x0_zero_R2: assert property (@(posedge clk) disable iff (rst)
    regs[0] == 32'd0);

  assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc == $past(pc) + 32'd4);

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (rst)
    (is_br && br_taken) |=> pc == $past(pc) + $past(imm));

  assert_jalr_even_R7: assert property (@(posedge clk) disable iff (rst)
    is_jalr |=> pc[0] == 1'b0);

  assert_store_no_rf_R9: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);
endmodule

// File: tb/rv32_onecycle_core_tb.sv
module rv32_onecycle_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;
  localparam logic [6:0] OPC_REG = 7'b0110011, OPC_IMM = 7'b0010011, OPC_LOAD = 7'b0000011,
                         OPC_JALR = 7'b1100111, OPC_LUI = 7'b0110111, OPC_AUIPC = 7'b0010111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int wp, total, bad, misal;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv32_onecycle_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we));

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  always @(negedge clk) if (!rst && imem_addr[1:0] != 2'b00) misal++;

  function automatic logic [31:0] r_ins(input logic [6:0] f7, input logic [4:0] s2, s1,
                                        input logic [2:0] fn, input logic [4:0] d);
    return {f7, s2, s1, fn, d, OPC_REG};
  endfunction
  function automatic logic [31:0] i_ins(input logic [11:0] im, input logic [4:0] s1,
                                        input logic [2:0] fn, input logic [4:0] d, input logic [6:0] op);
    return {im, s1, fn, d, op};
  endfunction
  function automatic logic [31:0] s_ins(input logic [11:0] im, input logic [4:0] s2, s1);
    return {im[11:5], s2, s1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] b_ins(input logic [12:0] im, input logic [4:0] s2, s1,
                                        input logic [2:0] fn);
    return {im[12], im[10:5], s2, s1, fn, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] u_ins(input logic [19:0] im, input logic [4:0] d, input logic [6:0] op);
    return {im, d, op};
  endfunction
  function automatic logic [31:0] j_ins(input logic [20:0] im, input logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, 7'b1101111};
  endfunction

  // {instruction, expected x5, add-own-pc flag}; x1=-16, x2=3, x3=0x12345000, x4=0x100
  localparam logic [64:0] VEC [NV] = '{
    {r_ins(7'h00, 2, 1, 3'd0, 5), 32'hFFFF_FFF3, 1'b0},                 // R3 add
    {r_ins(7'h20, 1, 2, 3'd0, 5), 32'h0000_0013, 1'b0},                 // R3 sub
    {r_ins(7'h00, 2, 1, 3'd1, 5), 32'hFFFF_FF80, 1'b0},                 // R3 sll
    {r_ins(7'h00, 2, 1, 3'd2, 5), 32'h0000_0001, 1'b0},                 // R3 slt
    {r_ins(7'h00, 2, 1, 3'd3, 5), 32'h0000_0000, 1'b0},                 // R3 sltu
    {r_ins(7'h00, 3, 1, 3'd4, 5), 32'hEDCB_AFF0, 1'b0},                 // R3 xor
    {r_ins(7'h00, 2, 1, 3'd5, 5), 32'h1FFF_FFFE, 1'b0},                 // R3 srl
    {r_ins(7'h20, 2, 1, 3'd5, 5), 32'hFFFF_FFFE, 1'b0},                 // R3 sra
    {r_ins(7'h00, 3, 2, 3'd6, 5), 32'h1234_5003, 1'b0},                 // R3 or
    {r_ins(7'h00, 3, 1, 3'd7, 5), 32'h1234_5000, 1'b0},                 // R3 and
    {i_ins(12'hFCE, 2, 3'd0, 5, OPC_IMM), 32'hFFFF_FFD1, 1'b0},         // R4 addi -50
    {i_ins(12'h004, 2, 3'd2, 5, OPC_IMM), 32'h0000_0001, 1'b0},         // R4 slti
    {i_ins(12'hFFF, 2, 3'd3, 5, OPC_IMM), 32'h0000_0001, 1'b0},         // R4 sltiu
    {i_ins(12'hFFF, 1, 3'd4, 5, OPC_IMM), 32'h0000_000F, 1'b0},         // R4 xori
    {i_ins(12'h7F0, 2, 3'd6, 5, OPC_IMM), 32'h0000_07F3, 1'b0},         // R4 ori
    {i_ins(12'h0FF, 1, 3'd7, 5, OPC_IMM), 32'h0000_00F0, 1'b0},         // R4 andi
    {i_ins(12'h004, 2, 3'd1, 5, OPC_IMM), 32'h0000_0030, 1'b0},         // R4 slli
    {i_ins(12'h01C, 1, 3'd5, 5, OPC_IMM), 32'h0000_000F, 1'b0},         // R4 srli
    {i_ins(12'h402, 1, 3'd5, 5, OPC_IMM), 32'hFFFF_FFFC, 1'b0},         // R4 srai
    {i_ins(12'h400, 2, 3'd0, 5, OPC_IMM), 32'h0000_0403, 1'b0},         // R4 addi with bit 30 set
    {u_ins(20'hABCDE, 5, OPC_LUI), 32'hABCD_E000, 1'b0},                // R5 lui
    {u_ins(20'h00001, 5, OPC_AUIPC), 32'h0000_1000, 1'b1},              // R5 auipc
    {i_ins(12'h000, 4, 3'd2, 5, OPC_LOAD), 32'h80F1_7F85, 1'b0},        // R8 lw
    {i_ins(12'h000, 4, 3'd0, 5, OPC_LOAD), 32'hFFFF_FF85, 1'b0},        // R8 lb
    {i_ins(12'h003, 4, 3'd4, 5, OPC_LOAD), 32'h0000_0080, 1'b0},        // R8 lbu
    {i_ins(12'h002, 4, 3'd1, 5, OPC_LOAD), 32'hFFFF_80F1, 1'b0},        // R8 lh
    {i_ins(12'h000, 4, 3'd5, 5, OPC_LOAD), 32'h0000_7F85, 1'b0},        // R8 lhu
    {i_ins(12'h001, 4, 3'd0, 5, OPC_LOAD), 32'h0000_007F, 1'b0},        // R8 lb positive
    {j_ins(21'd4, 5), 32'h0000_0004, 1'b1},                             // R7 jal link
    {r_ins(7'h20, 2, 1, 3'd0, 5), 32'hFFFF_FFED, 1'b0}                  // R3 sub negative
  };

  task automatic emit(input logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_to(input int hpc);
    int n;
    n = 0;
    while (imem_addr !== hpc[31:0] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", imem_addr, hpc[31:0]);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int jpc, apc, hpc;
    total = 0; bad = 0; misal = 0;
    for (int k = 0; k < 256; k++) begin imem[k] = 32'h0000_0013; dmem[k] = 32'd0; end
    dmem[64]  = 32'h80F1_7F85;
    dmem[199] = 32'hDEAD_BEEF;
    dmem[200] = 32'hC0FF_EE00;

    wp = 0;
    emit(i_ins(12'hFF0, 0, 3'd0, 1, OPC_IMM));
    emit(i_ins(12'h003, 0, 3'd0, 2, OPC_IMM));
    emit(u_ins(20'h12345, 3, OPC_LUI));
    emit(i_ins(12'h100, 0, 3'd0, 4, OPC_IMM));
    for (int i = 0; i < NV; i++) begin
      emit(VEC[i][64:33]);
      emit(s_ins(12'(12'h200 + 4 * i), 5, 0));
    end
    emit(b_ins(13'd8, 2, 2, 3'd0)); emit(i_ins(12'd1,   6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 2, 3'd1)); emit(i_ins(12'd2,   6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd4)); emit(i_ins(12'd4,   6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd5)); emit(i_ins(12'd8,   6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd6)); emit(i_ins(12'd16,  6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd7)); emit(i_ins(12'd32,  6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd0)); emit(i_ins(12'd64,  6, 3'd0, 6, OPC_IMM));
    emit(b_ins(13'd8, 2, 1, 3'd1)); emit(i_ins(12'd128, 6, 3'd0, 6, OPC_IMM));
    emit(s_ins(12'h300, 6, 0));
    emit(i_ins(12'd3, 0, 3'd0, 7, OPC_IMM));
    emit(i_ins(12'd1, 8, 3'd0, 8, OPC_IMM));
    emit(i_ins(12'hFFF, 7, 3'd0, 7, OPC_IMM));
    emit(b_ins(13'h1FF8, 0, 7, 3'd1));
    emit(s_ins(12'h304, 8, 0));
    emit(s_ins(12'h308, 7, 0));
    jpc = wp * 4;
    emit(j_ins(21'd12, 9));
    emit(i_ins(12'd1, 10, 3'd0, 10, OPC_IMM));
    emit(i_ins(12'd1, 10, 3'd0, 10, OPC_IMM));
    emit(s_ins(12'h30C, 9, 0));
    emit(s_ins(12'h310, 10, 0));
    apc = wp * 4;
    emit(u_ins(20'd0, 11, OPC_AUIPC));
    emit(i_ins(12'd13, 11, 3'd0, 12, OPC_JALR));
    emit(i_ins(12'd1, 10, 3'd0, 10, OPC_IMM));
    emit(s_ins(12'h314, 12, 0));
    emit(s_ins(12'h318, 10, 0));
    emit(i_ins(12'd7, 2, 3'd0, 0, OPC_IMM));
    emit(s_ins(12'h31C, 0, 0));
    emit(s_ins(12'hFFC, 2, 4));
    hpc = wp * 4;
    emit(j_ins(21'd0, 0));

    repeat (3) @(negedge clk);
    check("R10 reset pc", imem_addr, 32'd0);
    check("R10 no store in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pc after one edge", imem_addr, 32'd4);
    run_to(hpc);

    for (int i = 0; i < NV; i++)
      check($sformatf("R3/R4/R5/R7/R8 vector %0d", i), dmem[128 + i],
            VEC[i][32:1] + (VEC[i][0] ? 32'(16 + 8 * i) : 32'd0));
    check("R6 branch outcome mask", dmem[192], 32'h0000_005A);
    check("R6 backward loop count", dmem[193], 32'd3);
    check("R6 loop counter end", dmem[194], 32'd0);
    check("R7 jal link", dmem[195], 32'(jpc + 4));
    check("R7 jal skipped", dmem[196], 32'd0);
    check("R7 jalr link", dmem[197], 32'(apc + 8));
    check("R7 jalr skipped", dmem[198], 32'd0);
    check("R2 x0 write discarded", dmem[199], 32'd0);
    check("R9 negative offset store", dmem[63], 32'd3);
    check("R9 no stray write", dmem[200], 32'hC0FF_EE00);
    check("R8 load source intact", dmem[64], 32'h80F1_7F85);
    check("R7 fetch address aligned", 32'(misal), 32'd0);
    check("R1 halt self-loop", imem_addr, 32'(hpc));

    for (int k = 224; k < 228; k++) dmem[k] = 32'hDEAD_BEEF;
    wp = 0;
    emit(s_ins(12'h380, 1, 0));
    emit(s_ins(12'h384, 5, 0));
    emit(s_ins(12'h388, 9, 0));
    emit(s_ins(12'h38C, 12, 0));
    emit(j_ins(21'd0, 0));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset pc mid-run", imem_addr, 32'd0);
    rst = 1'b0;
    run_to(16);
    check("R10 x1 cleared", dmem[224], 32'd0);
    check("R10 x5 cleared", dmem[225], 32'd0);
    check("R10 x9 cleared", dmem[226], 32'd0);
    check("R10 x12 cleared", dmem[227], 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule